// File: doc/BRIEF.md
# Instruction Register Select and Dual-Write Register Bank

This block is the operand-fetch and result-commit slice of a single-cycle 64-bit processor. From the 4-bit instruction class code and the two 4-bit register fields of the current instruction, it picks two read indices and two write indices. It holds fifteen 64-bit general registers. The stack pointer sits at a fixed index, 4. Index 15 is a dummy: it means "no register" for reads and for writes.

The two read values are returned combinationally from the selected read indices, so the ALU and the data memory see them within the same cycle. On each rising clock edge the bank commits two results. The ALU result is written to the E destination and the memory result to the M destination. A pop therefore updates both the stack pointer and its target register in one instruction. A conditional move whose condition is false turns into a no-write on the E port.

The block has no state machine. Its only sequential element is the register array, which has one reset state (all zeros) and one update rule per clock edge.

Top module: `regsel_wb_core`

## Requirements
- R1: Class codes are 0 halt, 1 nop, 2 register move/conditional move, 3 immediate load, 4 store, 5 load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 push, 11 pop; codes 12 to 15 behave like nop. Read index A is field A for codes 2, 4, 6 and 10, index 4 for codes 9 and 11, and 15 for every other code.
- R2: Read index B is field B for codes 4, 5 and 6, index 4 for codes 8, 9, 10 and 11, and 15 otherwise.
- R3: Write index E is field B for codes 3 and 6, and for code 2 when the condition input is 1. It is 15 for code 2 when the condition input is 0. It is index 4 for codes 8, 9, 10 and 11, and 15 otherwise.
- R4: Write index M is field A for codes 5 and 11, and 15 otherwise.
- R5: Read values are combinational copies of the selected registers; a read index of 15 returns zero.
- R6: On a rising edge the ALU result is stored at write index E. A read in the same cycle still shows the value from before that edge.
- R7: On the same edge the memory result is stored at write index M, so a pop updates two registers at once.
- R8: When both write indices name the same register, that register takes the memory result.
- R9: A write index of 15 stores nothing, and no register other than the two write indices changes on an edge.
- R10: An active-low reset clears all fifteen registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_code | input | 4 | Instruction class code |
| reg_fld_a | input | 4 | First register field of the instruction |
| reg_fld_b | input | 4 | Second register field of the instruction |
| cond_ok | input | 1 | Conditional-move outcome |
| alu_result | input | 64 | Value for the E write port |
| mem_result | input | 64 | Value for the M write port |
| sel_rd_a | output | 4 | Selected read index A |
| sel_rd_b | output | 4 | Selected read index B |
| sel_wr_e | output | 4 | Selected write index E |
| sel_wr_m | output | 4 | Selected write index M |
| rd_val_a | output | 64 | Value of register at read index A |
| rd_val_b | output | 64 | Value of register at read index B |

## Verification
On every cycle, assertions check the following:
- that each write lands at its index one edge later;
- that a shared target keeps the memory result;
- that every untargeted register holds its value;
- that a false conditional move and every M-port write stay within the rules of the field selection;
- that the dummy index reads as zero.

The full per-code selection table can only be shown by the bench's scenarios. So can reset contents, read-before-write ordering within a cycle, and the fact that halt, jump and unused codes leave stored values untouched. The bench shows these by reading registers back through the read ports.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
    localparam int IDX_W = 4;

    typedef enum logic [IDX_W-1:0] {
        IC_HALT  = 4'd0,
        IC_NOP   = 4'd1,
        IC_MOVE  = 4'd2,
        IC_LDIMM = 4'd3,
        IC_STORE = 4'd4,
        IC_LOAD  = 4'd5,
        IC_ALU   = 4'd6,
        IC_JUMP  = 4'd7,
        IC_CALL  = 4'd8,
        IC_RET   = 4'd9,
        IC_PUSH  = 4'd10,
        IC_POP   = 4'd11
    } instr_class_e;

    localparam logic [IDX_W-1:0] IDX_NONE = 4'hF;
    localparam logic [IDX_W-1:0] IDX_SP   = 4'd4;
endpackage

// File: rtl/port_select.sv
module port_select
    import regsel_pkg::*;
(
    input  logic [IDX_W-1:0] instr_code,
    input  logic [IDX_W-1:0] fld_a,
    input  logic [IDX_W-1:0] fld_b,
    input  logic             cond_ok,
    output logic [IDX_W-1:0] rd_a,
    output logic [IDX_W-1:0] rd_b,
    output logic [IDX_W-1:0] wr_e,
    output logic [IDX_W-1:0] wr_m
);
    instr_class_e cls;
    assign cls = instr_class_e'(instr_code);

    always_comb begin
        rd_a = IDX_NONE;
        rd_b = IDX_NONE;
        wr_e = IDX_NONE;
        wr_m = IDX_NONE;
        unique case (cls)
            IC_MOVE: begin
                rd_a = fld_a;
                wr_e = cond_ok ? fld_b : IDX_NONE;
            end
            IC_LDIMM: wr_e = fld_b;
            IC_STORE: begin
                rd_a = fld_a;
                rd_b = fld_b;
            end
            IC_LOAD: begin
                rd_b = fld_b;
                wr_m = fld_a;
            end
            IC_ALU: begin
                rd_a = fld_a;
                rd_b = fld_b;
                wr_e = fld_b;
            end
            IC_CALL: begin
                rd_b = IDX_SP;
                wr_e = IDX_SP;
            end
            IC_RET: begin
                rd_a = IDX_SP;
                rd_b = IDX_SP;
                wr_e = IDX_SP;
            end
            IC_PUSH: begin
                rd_a = fld_a;
                rd_b = IDX_SP;
                wr_e = IDX_SP;
            end
            IC_POP: begin
                rd_a = IDX_SP;
                rd_b = IDX_SP;
                wr_e = IDX_SP;
                wr_m = fld_a;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int XLEN  = 64,
    parameter int NREG  = 15,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a,
    input  logic [IDX_W-1:0] rd_b,
    input  logic [IDX_W-1:0] wr_e,
    input  logic [IDX_W-1:0] wr_m,
    input  logic [XLEN-1:0]  wd_e,
    input  logic [XLEN-1:0]  wd_m,
    output logic [XLEN-1:0]  rv_a,
    output logic [XLEN-1:0]  rv_b
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NREG);

    logic [XLEN-1:0] regs [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (wr_m == MY_IDX)
                    regs[i] <= wd_m;
                else if (wr_e == MY_IDX)
                    regs[i] <= wd_e;
            end

            // R9: a register named by neither write index keeps its value
            a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_e != MY_IDX && wr_m != MY_IDX) |=> $stable(regs[i]));
        end
    endgenerate

    assign rv_a = (rd_a < LIMIT) ? regs[rd_a] : '0;
    assign rv_b = (rd_b < LIMIT) ? regs[rd_b] : '0;

    // R6: an E write is visible after the edge unless the M port took the slot
    a_r6_e_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_e < LIMIT && wr_e != wr_m) |=> regs[$past(wr_e)] == $past(wd_e));

    // R7: an M write is visible after the edge
    a_r7_m_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_m < LIMIT) |=> regs[$past(wr_m)] == $past(wd_m));

    // R8: a shared target keeps the memory result
    a_r8_m_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_m < LIMIT && wr_e == wr_m) |=> regs[$past(wr_e)] == $past(wd_m));
endmodule

// File: rtl/regsel_wb_core.sv
module regsel_wb_core
    import regsel_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       instr_code,
    input  logic [3:0]       reg_fld_a,
    input  logic [3:0]       reg_fld_b,
    input  logic             cond_ok,
    input  logic [XLEN-1:0]  alu_result,
    input  logic [XLEN-1:0]  mem_result,
    output logic [3:0]       sel_rd_a,
    output logic [3:0]       sel_rd_b,
    output logic [3:0]       sel_wr_e,
    output logic [3:0]       sel_wr_m,
    output logic [XLEN-1:0]  rd_val_a,
    output logic [XLEN-1:0]  rd_val_b
);
    port_select u_sel (
        .instr_code (instr_code),
        .fld_a      (reg_fld_a),
        .fld_b      (reg_fld_b),
        .cond_ok    (cond_ok),
        .rd_a       (sel_rd_a),
        .rd_b       (sel_rd_b),
        .wr_e       (sel_wr_e),
        .wr_m       (sel_wr_m)
    );

    // R3: a move with a false condition must not write on the E port
    a_r3_cmov_off: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_code == IC_MOVE && !cond_ok) |-> sel_wr_e == IDX_NONE);

    // R4: the M port only ever targets the first field
    a_r4_m_from_a: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr_m != IDX_NONE) |-> sel_wr_m == reg_fld_a);

    // R7: a pop drives both write ports
    a_r7_pop_dual: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_code == IC_POP) |-> (sel_wr_e == IDX_SP && sel_wr_m == reg_fld_a));

    reg_bank #(
        .XLEN  (XLEN),
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_a  (sel_rd_a),
        .rd_b  (sel_rd_b),
        .wr_e  (sel_wr_e),
        .wr_m  (sel_wr_m),
        .wd_e  (alu_result),
        .wd_m  (mem_result),
        .rv_a  (rd_val_a),
        .rv_b  (rd_val_b)
    );

    // R5: the dummy index reads as zero
    a_r5_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rd_a == IDX_NONE) |-> rd_val_a == '0);
endmodule

// File: tb/regsel_wb_core_test.sv
module regsel_wb_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  instr_code = 4'd0;
    logic [3:0]  reg_fld_a = 4'd0;
    logic [3:0]  reg_fld_b = 4'd0;
    logic        cond_ok = 1'b0;
    logic [63:0] alu_result = '0;
    logic [63:0] mem_result = '0;
    logic [3:0]  sel_rd_a, sel_rd_b, sel_wr_e, sel_wr_m;
    logic [63:0] rd_val_a, rd_val_b;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [63:0] model [15];

    always #10 clk = ~clk;

    regsel_wb_core uut (
        .clk(clk), .rst_n(rst_n), .instr_code(instr_code),
        .reg_fld_a(reg_fld_a), .reg_fld_b(reg_fld_b), .cond_ok(cond_ok),
        .alu_result(alu_result), .mem_result(mem_result),
        .sel_rd_a(sel_rd_a), .sel_rd_b(sel_rd_b),
        .sel_wr_e(sel_wr_e), .sel_wr_m(sel_wr_m),
        .rd_val_a(rd_val_a), .rd_val_b(rd_val_b)
    );

    function automatic logic [3:0] e_src_a(logic [3:0] ic, logic [3:0] a);
        if (ic == 2 || ic == 4 || ic == 6 || ic == 10) return a;
        if (ic == 9 || ic == 11) return 4'd4;
        return 4'hF;
    endfunction

    function automatic logic [3:0] e_src_b(logic [3:0] ic, logic [3:0] b);
        if (ic == 4 || ic == 5 || ic == 6) return b;
        if (ic >= 8 && ic <= 11) return 4'd4;
        return 4'hF;
    endfunction

    function automatic logic [3:0] e_dst_e(logic [3:0] ic, logic [3:0] b, logic c);
        if (ic == 3 || ic == 6) return b;
        if (ic == 2) return c ? b : 4'hF;
        if (ic >= 8 && ic <= 11) return 4'd4;
        return 4'hF;
    endfunction

    function automatic logic [3:0] e_dst_m(logic [3:0] ic, logic [3:0] a);
        if (ic == 5 || ic == 11) return a;
        return 4'hF;
    endfunction

    function automatic logic [63:0] rd_model(logic [3:0] idx);
        return (idx == 4'hF) ? 64'd0 : model[idx];
    endfunction

    task automatic push(int kind, logic [63:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic step(input logic [3:0] ic, input logic [3:0] a, input logic [3:0] b,
                        input logic c, input logic [63:0] ve, input logic [63:0] vm,
                        input string tag);
        logic [3:0] sa, sbi, de, dm;
        @(negedge clk);
        instr_code = ic; reg_fld_a = a; reg_fld_b = b;
        cond_ok = c; alu_result = ve; mem_result = vm;
        #5;
        sa  = e_src_a(ic, a);
        sbi = e_src_b(ic, b);
        de  = e_dst_e(ic, b, c);
        dm  = e_dst_m(ic, a);
        push(0, {60'd0, sa}, tag);
        push(1, {60'd0, sbi}, tag);
        push(2, {60'd0, de}, tag);
        push(3, {60'd0, dm}, tag);
        push(4, rd_model(sa), tag);
        push(5, rd_model(sbi), tag);
        if (de != 4'hF) model[de] = ve;
        if (dm != 4'hF) model[dm] = vm;
    endtask

    always @(negedge clk) begin
        #7;
        while (sb.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = {60'd0, sel_rd_a};
                1: act = {60'd0, sel_rd_b};
                2: act = {60'd0, sel_wr_e};
                3: act = {60'd0, sel_wr_m};
                4: act = rd_val_a;
                default: act = rd_val_b;
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 15; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: registers read as zero after reset
        step(4, 0, 1, 0, 64'h0, 64'h0, "R10");
        step(4, 4, 14, 0, 64'h0, 64'h0, "R10");
        // R6: immediate load then read back
        step(3, 0, 3, 0, 64'hA1A1_0000_0000_00A1, 64'h0, "R3/R6");
        step(4, 3, 3, 0, 64'h0, 64'h0, "R6");
        // R3: conditional move taken / not taken
        step(2, 3, 5, 1, 64'hB2B2_B2B2_0000_0002, 64'h0, "R1/R3");
        step(2, 3, 5, 0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0, "R3/R9");
        step(4, 5, 5, 0, 64'h0, 64'h0, "R9");
        // R4: load writes field A from memory
        step(5, 7, 3, 0, 64'h1111, 64'hC3C3_0000_C3C3_0000, "R2/R4/R7");
        // R7: pop writes two registers at once
        step(11, 2, 0, 0, 64'h100, 64'hD4D4_D4D4_D4D4_D4D4, "R7");
        step(4, 2, 4, 0, 64'h0, 64'h0, "R7");
        // R8: pop into the stack pointer keeps the memory value
        step(11, 4, 0, 0, 64'h200, 64'hE5E5_0000_0000_E5E5, "R8");
        step(4, 4, 4, 0, 64'h0, 64'h0, "R8");
        step(10, 2, 9, 0, 64'h1F8, 64'h0, "R1/R2/R3");
        step(8, 6, 6, 0, 64'h1F0, 64'h5555, "R1/R2/R3/R4");
        step(9, 6, 6, 0, 64'h1F8, 64'h7777, "R1/R2/R4");
        // R9: halt, nop, jump and unused codes store nothing
        step(0, 1, 1, 1, 64'hFFFF, 64'hFFFF, "R1/R9");
        step(1, 1, 1, 1, 64'hFFFF, 64'hFFFF, "R1/R9");
        step(7, 1, 7, 1, 64'hFFFF, 64'hFFFF, "R1/R9");
        step(12, 1, 7, 1, 64'hFFFF, 64'hFFFF, "R1/R9");
        step(4, 1, 7, 0, 64'h0, 64'h0, "R9");
        // R5: dummy index reads zero and disables the write
        step(6, 15, 15, 0, 64'h4242, 64'h0, "R5/R9");
        step(6, 3, 6, 0, 64'h77, 64'h0, "R2/R3/R6");
        step(4, 6, 15, 0, 64'h0, 64'h0, "R5/R6");
        repeat (2) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule